// File: doc/BRIEF.md
# Serial Channel Word Loader

This block is the programming port of a frequency synthesizer's channel divider. A host drives three slow wires: a serial data line, a shift clock and a latch strobe. The block samples all three with a faster system clock, passes each through a two-flop synchronizer and finds the rising edges. Each rising edge of the shift clock pushes the current data bit into a 7-bit shift register, most significant bit first. A rising edge of the latch strobe copies the shifted word to a holding register, which drives the divider's channel input.

The divider accepts only channel codes 0 to 85, and code 1 is forbidden. When a latched word falls outside that set, the block drops its valid flag and leaves the last good channel on the divider. The next legal word raises the flag again. Reset selects channel 0 with the flag set.

Top module: `serial_chan_loader`

## Requirements
- R1: After a synchronous reset, `chan_o` is 0 and `chan_ok_o` is 1. The internal shift word is also 0, so a latch strobe with no shifting loads channel 0.
- R2: Each rising edge of `ser_clk_i` shifts in the level of `ser_dat_i`. The word is 7 bits and the first bit sent is the most significant, so channel 10 is sent as 0,0,0,1,0,1,0.
- R3: When more than seven bits are shifted before a strobe, only the last seven bits received are latched.
- R4: Shift clock edges alone never change `chan_o` or `chan_ok_o`. Both outputs change only after a rising edge of `ser_le_i`.
- R5: A latched code from 0 to 85 other than 1 appears on `chan_o`, and `chan_ok_o` becomes 1.
- R6: A latched code of 1 sets `chan_ok_o` to 0 and leaves `chan_o` at its previous value.
- R7: A latched code from 86 to 127 sets `chan_ok_o` to 0 and leaves `chan_o` at its previous value.
- R8: After a rejected code, the next legal code restores `chan_ok_o` to 1 and appears on `chan_o`.
- R9: If `ser_le_i` is driven high between two system clock edges, the outputs are unchanged after the next two rising edges of `clk` and updated after the third. Each serial input level must be held for at least two system clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial port |
| rst | input | 1 | Synchronous reset, active high |
| ser_clk_i | input | 1 | Serial shift clock, asynchronous to `clk` |
| ser_dat_i | input | 1 | Serial data bit, asynchronous to `clk` |
| ser_le_i | input | 1 | Latch strobe, asynchronous to `clk` |
| chan_o | output | 7 | Channel code held for the divider |
| chan_ok_o | output | 1 | 1 when the last latched code was legal |

## Verification
The hardest case to reach is a rejected code that must leave the earlier channel in place. The check only means something if that earlier channel is not 0, because 0 is also the reset value. The stimulus table therefore loads a nonzero legal channel before each forbidden or out-of-range word. It then loads a legal word right after the rejected one, to show that the flag recovers. A directed case shifts nine bits so that the two oldest bits fall off the top of the register. A second directed case places the strobe edge between clock edges and counts cycles to confirm the latency.

// File: rtl/cwl_pkg.sv
package cwl_pkg;

    localparam int unsigned CHAN_W = 7;
    localparam logic [CHAN_W-1:0] CHAN_TOP = CHAN_W'(85);
    localparam logic [CHAN_W-1:0] CHAN_HOLE = CHAN_W'(1);
    localparam logic [CHAN_W-1:0] CHAN_RST = '0;

    // bit order of the synchronized serial lines
    localparam int unsigned LN_CLK = 0;
    localparam int unsigned LN_DAT = 1;
    localparam int unsigned LN_LE = 2;
    localparam int unsigned LN_NUM = 3;

    typedef logic [CHAN_W-1:0] chan_t;

    typedef struct packed {
        logic shift_rise;
        logic strobe_rise;
        logic bit_val;
    } ser_evt_t;

    typedef struct packed {
        chan_t code;
        logic ok;
    } hold_t;

    function automatic logic chan_legal(input chan_t c);
        return (c <= CHAN_TOP) && (c != CHAN_HOLE);
    endfunction

endpackage

// File: rtl/cwl_sync.sv
module cwl_sync #(
    parameter int unsigned W = 3,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stg [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stg[g] <= '0;
                else     stg[g] <= din;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stg[g] <= '0;
                else     stg[g] <= stg[g-1];
            end
        end
    end

    assign dout = stg[STAGES-1];
endmodule

// File: rtl/cwl_edge.sv
module cwl_edge
    import cwl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [LN_NUM-1:0] lvl,
    output ser_evt_t          evt
);
    logic clk_prev;
    logic le_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            clk_prev <= 1'b0;
            le_prev  <= 1'b0;
        end else begin
            clk_prev <= lvl[LN_CLK];
            le_prev  <= lvl[LN_LE];
        end
    end

    always_comb begin
        evt.shift_rise  = lvl[LN_CLK] & ~clk_prev;
        evt.strobe_rise = lvl[LN_LE] & ~le_prev;
        evt.bit_val     = lvl[LN_DAT];
    end
endmodule

// File: rtl/cwl_shift.sv
module cwl_shift
    import cwl_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  ser_evt_t evt,
    output chan_t    word
);
    always_ff @(posedge clk) begin
        if (rst)                 word <= '0;
        else if (evt.shift_rise) word <= {word[CHAN_W-2:0], evt.bit_val};
    end
endmodule

// File: rtl/cwl_hold.sv
module cwl_hold
    import cwl_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  take,
    input  chan_t word,
    output hold_t held
);
    hold_t nxt;

    always_comb begin
        nxt = held;
        if (take) begin
            if (chan_legal(word)) begin
                nxt.code = word;
                nxt.ok   = 1'b1;
            end else begin
                nxt.ok   = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            held.code <= CHAN_RST;
            held.ok   <= 1'b1;
        end else begin
            held <= nxt;
        end
    end
endmodule

// File: rtl/serial_chan_loader.sv
module serial_chan_loader
    import cwl_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ser_clk_i,
    input  logic              ser_dat_i,
    input  logic              ser_le_i,
    output logic [CHAN_W-1:0] chan_o,
    output logic              chan_ok_o
);
    logic [LN_NUM-1:0] raw_lines;
    logic [LN_NUM-1:0] sync_lines;
    ser_evt_t          evt;
    chan_t             word_q;
    hold_t             held;
    logic              shift_rise;
    logic              strobe_rise;
    logic              bit_val;

    always_comb begin
        raw_lines         = '0;
        raw_lines[LN_CLK] = ser_clk_i;
        raw_lines[LN_DAT] = ser_dat_i;
        raw_lines[LN_LE]  = ser_le_i;
    end

    cwl_sync #(.W(LN_NUM), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .din (raw_lines),
        .dout(sync_lines)
    );

    cwl_edge u_edge (
        .clk(clk),
        .rst(rst),
        .lvl(sync_lines),
        .evt(evt)
    );

    assign shift_rise  = evt.shift_rise;
    assign strobe_rise = evt.strobe_rise;
    assign bit_val     = evt.bit_val;

    cwl_shift u_shift (
        .clk (clk),
        .rst (rst),
        .evt (evt),
        .word(word_q)
    );

    cwl_hold u_hold (
        .clk (clk),
        .rst (rst),
        .take(strobe_rise),
        .word(word_q),
        .held(held)
    );

    assign chan_o    = held.code;
    assign chan_ok_o = held.ok;
endmodule

// File: rtl/cwl_chk.sv
module cwl_chk
    import cwl_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [CHAN_W-1:0] chan_o,
    input logic              chan_ok_o,
    input logic [CHAN_W-1:0] word,
    input logic              shift_rise,
    input logic              strobe_rise,
    input logic              bit_val
);
    AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (chan_o == CHAN_RST && chan_ok_o)); // R1

    AST_SHIFT_IN: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(shift_rise)) |->
            (word == {$past(word[CHAN_W-2:0]), $past(bit_val)})); // R2

    AST_QUIET_NO_STROBE: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(strobe_rise)) |->
            ($stable(chan_o) && $stable(chan_ok_o))); // R4

    AST_TAKE_LEGAL: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(strobe_rise) && chan_legal($past(word))) |->
            (chan_o == $past(word) && chan_ok_o)); // R5

    AST_REJECT_KEEP: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(strobe_rise) && !chan_legal($past(word))) |->
            (!chan_ok_o && $stable(chan_o))); // R6

    AST_OUT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        chan_legal(chan_o)); // R7
endmodule

bind serial_chan_loader cwl_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .chan_o     (chan_o),
    .chan_ok_o  (chan_ok_o),
    .word       (word_q),
    .shift_rise (shift_rise),
    .strobe_rise(strobe_rise),
    .bit_val    (bit_val)
);

// File: tb/sim_serial_chan_loader.sv
`timescale 1ns/1ps
module sim_serial_chan_loader;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sck = 1'b0;
    logic       sdat = 1'b0;
    logic       sle = 1'b0;
    logic [6:0] chan;
    logic       ok;
    int         checks = 0;
    int         errors = 0;
    bit         done = 1'b0;

    always #2.5 clk = ~clk;

    serial_chan_loader u0 (
        .clk      (clk),
        .rst      (rst),
        .ser_clk_i(sck),
        .ser_dat_i(sdat),
        .ser_le_i (sle),
        .chan_o   (chan),
        .chan_ok_o(ok)
    );

    // {code shifted, expected channel, expected flag}
    localparam int NV = 10;
    localparam logic [14:0] VEC [NV] = '{
        {7'd10,  7'd10, 1'b1},   // R2 R5 channel ten, MSB first
        {7'd0,   7'd0,  1'b1},   // R5 lowest
        {7'd42,  7'd42, 1'b1},   // R5
        {7'd1,   7'd42, 1'b0},   // R6 forbidden code keeps 42
        {7'd85,  7'd85, 1'b1},   // R8 R5 top legal
        {7'd86,  7'd85, 1'b0},   // R7 just above range
        {7'd127, 7'd85, 1'b0},   // R7 all ones
        {7'd2,   7'd2,  1'b1},   // R8 recovery
        {7'd1,   7'd2,  1'b0},   // R6
        {7'd84,  7'd84, 1'b1}    // R8
    };

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input int act, input int exp, input string tag);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        sdat = b;
        wait_n(2);
        sck = 1'b1;
        wait_n(4);
        sck = 1'b0;
        wait_n(2);
    endtask

    task automatic send_word(input logic [6:0] w);
        for (int i = 6; i >= 0; i--) send_bit(w[i]);
    endtask

    task automatic strobe();
        sle = 1'b1;
        wait_n(4);
        sle = 1'b0;
        wait_n(4);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual %0d expected %0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        wait_n(3);
        rst = 1'b0;
        wait_n(1);
        check(chan, 0, "R1 chan");
        check(ok, 1, "R1 ok");

        for (int v = 0; v < NV; v++) begin
            send_word(VEC[v][14:8]);
            strobe();
            check(chan, VEC[v][7:1], "R5-table chan");
            check(ok, VEC[v][0], "R5-table ok");
        end

        // R4: shifting without a strobe leaves outputs alone (now 84,1)
        send_word(7'd33);
        check(chan, 84, "R4 chan");
        check(ok, 1, "R4 ok");
        strobe();
        check(chan, 33, "R4 after strobe");

        // R3: nine bits 1,1 then 21; only the last seven count
        send_bit(1'b1);
        send_bit(1'b1);
        send_word(7'd21);
        strobe();
        check(chan, 21, "R3 chan");
        check(ok, 1, "R3 ok");

        // R9: latency from strobe to output
        send_word(7'd55);
        sle = 1'b1;
        wait_n(2);
        check(chan, 21, "R9 two edges");
        wait_n(1);
        check(chan, 55, "R9 three edges");
        wait_n(3);
        sle = 1'b0;
        wait_n(4);

        // R6 after nonzero channel, then R8 recovery via code 3
        send_word(7'd1);
        strobe();
        check(chan, 55, "R6 keep");
        check(ok, 0, "R6 ok");
        send_word(7'd3);
        strobe();
        check(ok, 1, "R8 ok");
        check(chan, 3, "R8 chan");

        // R1: reset mid-run clears output and shift word
        send_word(7'd70);
        rst = 1'b1;
        wait_n(2);
        rst = 1'b0;
        wait_n(1);
        check(chan, 0, "R1 chan after reset");
        check(ok, 1, "R1 ok after reset");
        strobe();
        check(chan, 0, "R1 empty word");
        check(ok, 1, "R1 empty ok");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule